// File: doc/BRIEF.md
# Signal Level Acquisition Controller

This block estimates the upper and lower peaks of a received, signed baseband sample stream. From those peaks it derives the DC offset and the amplitude that a downstream slicer needs. A one-cycle acquire command starts a fixed sequence of measurement modes:

- It first takes a straight mean over one bit period and loads that mean into both peak estimates.
- It then tracks the peaks quickly with a lossy detector that attacks fast and decays slowly.
- Finally it settles into a residual mode that software selects.

The change to the residual mode happens in one of two ways. If a frame-sync search was armed early enough, the change waits for the frame-sync-found pulse. Otherwise it happens on a fixed bit-count timeout.

One sample arrives on every clock. A bit strobe marks the last sample of each bit, and one bit period is `2**SPB_LOG2` samples. Every acquire command restarts the sequence from the beginning.

Top module: `lvl_acq_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (idle), and both peak estimates are 0.
- R2: An acquire pulse in any mode puts mode_o at 1 (averaging) on the next cycle and restarts the sequence: the bit count, the sample count, the accumulator and the armed flag are all cleared.
- R3: In averaging mode, the block sums the first 2**SPB_LOG2 samples after the acquire and takes the floor of their mean (arithmetic shift). The cycle after the last of those samples, both estimates equal that mean and mode_o is 2 (lossy tracking).
- R4: In lossy tracking, each estimate steps toward the sample by the floor of (sample - estimate) shifted right by 2 when the sample lies beyond it, and by 6 otherwise.
- R5: If sfs_armed_i is high on any cycle while fewer than 28 bit strobes have been counted since the acquire, lossy tracking lasts until a sfs_found_i pulse. It does so regardless of the bit count. The pulse puts mode_o at 3 (residual) on the next cycle.
- R6: If the search was not armed in that window, mode_o becomes 3 on the cycle after the bit count has reached 30. Arming at 28 or more counted bits has no effect.
- R7: In residual mode, res_mode_i selects the tracking rule:
  - 00: lossy tracking, as in R4.
  - 01: peak detect. An estimate jumps to any sample beyond it and otherwise holds.
  - 10: peak averaging. An estimate steps by (sample - estimate) shifted right by 4 when the sample lies on its side of the current dc_o.
  - 11: hold. Both estimates are frozen.
- R8: dc_o equals floor((pos + neg)/2), and amp_o equals floor((pos - neg)/2). Both follow the estimates in the same cycle.
- R9: With a 1100 bit pattern applied from the acquire, each estimate is within one eighth of the signal amplitude of its true peak by the end of the 16th bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | SAMPLE_W | Signed baseband sample, one per clock |
| bit_stb_i | input | 1 | High on the last sample of each bit |
| acq_i | input | 1 | Acquire-level command pulse |
| sfs_armed_i | input | 1 | Frame-sync search armed |
| sfs_found_i | input | 1 | Frame-sync found pulse |
| res_mode_i | input | 2 | Residual mode: 00 lossy, 01 peak, 10 averaging, 11 hold |
| pos_pk_o | output | SAMPLE_W | Positive peak estimate |
| neg_pk_o | output | SAMPLE_W | Negative peak estimate |
| dc_o | output | SAMPLE_W | DC offset, the midpoint of the peaks |
| amp_o | output | SAMPLE_W | Amplitude, half the peak difference |
| mode_o | output | 2 | 0 idle, 1 averaging, 2 lossy, 3 residual |

## Verification
The assertions check, on every cycle, the mode changes that can be stated locally:
- the restart on acquire;
- leaving idle only once;
- the exit from averaging;
- no early exit from lossy tracking;
- a sticky residual mode;
- frozen estimates in hold;
- lossy steps that never overshoot the sample;
- the jump-to-sample rule of peak detect.

Other behaviours need whole scenarios, so the bench's cycle model and its directed stimulus cover them. These are the exact seed mean, the arming window against the 30-bit timeout, settling on a 1100 pattern within 16 bits, and the averaging step.

// File: rtl/lvl_acq_pkg.sv
`timescale 1ns/1ps
package lvl_acq_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_AVG   = 2'd1,
    MODE_LOSSY = 2'd2,
    MODE_RESID = 2'd3
  } lvl_mode_e;

  typedef enum logic [1:0] {
    RES_LOSSY = 2'd0,
    RES_PEAK  = 2'd1,
    RES_AVG   = 2'd2,
    RES_HOLD  = 2'd3
  } res_mode_e;
endpackage

// File: rtl/lvl_seq.sv
`timescale 1ns/1ps
module lvl_seq
  import lvl_acq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int SPB_LOG2 = 3,
  parameter int BCNT_W   = 6,
  parameter int ARM_WIN  = 28,
  parameter int RES_BITS = 30
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       acq_i,
  input  logic                       bit_stb_i,
  input  logic                       sfs_armed_i,
  input  logic                       sfs_found_i,
  output lvl_mode_e                  mode_o,
  output logic                       seed_vld_o,
  output logic signed [SAMPLE_W-1:0] seed_o
);
  localparam int ACC_W = SAMPLE_W + SPB_LOG2;
  localparam logic [BCNT_W-1:0] BCNT_MAX = '1;
  localparam logic [BCNT_W-1:0] ARM_LIM  = BCNT_W'(ARM_WIN);
  localparam logic [BCNT_W-1:0] RES_LIM  = BCNT_W'(RES_BITS);

  lvl_mode_e                mode_q, mode_d;
  logic signed [ACC_W-1:0]  acc_q, acc_sum;
  logic [SPB_LOG2-1:0]      scnt_q;
  logic [BCNT_W-1:0]        bcnt_q;
  logic                     arm_q, arm_eff, last_smp, timeout;

  assign acc_sum  = acc_q + ACC_W'(sample_i);
  assign last_smp = &scnt_q;
  assign arm_eff  = arm_q | (sfs_armed_i & (bcnt_q < ARM_LIM));
  assign timeout  = bcnt_q >= RES_LIM;

  always_comb begin
    mode_d = mode_q;
    if (acq_i) mode_d = MODE_AVG;
    else begin
      unique case (mode_q)
        MODE_AVG:   if (last_smp) mode_d = MODE_LOSSY;
        MODE_LOSSY: if ((arm_eff && sfs_found_i) || (!arm_eff && timeout)) mode_d = MODE_RESID;
        default:    mode_d = mode_q;
      endcase
    end
  end

  logic signed [ACC_W-1:0] mean;
  assign mean       = acc_sum >>> SPB_LOG2;
  assign seed_vld_o = (mode_q == MODE_AVG) && last_smp;
  assign seed_o     = mean[SAMPLE_W-1:0];
  assign mode_o     = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      acc_q  <= '0;
      scnt_q <= '0;
      bcnt_q <= '0;
      arm_q  <= 1'b0;
    end else if (acq_i) begin
      mode_q <= MODE_AVG;
      acc_q  <= '0;
      scnt_q <= '0;
      bcnt_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (mode_q == MODE_AVG) begin
        acc_q  <= acc_sum;
        scnt_q <= scnt_q + 1'b1;
      end
      if (bit_stb_i && mode_q != MODE_IDLE && bcnt_q != BCNT_MAX) bcnt_q <= bcnt_q + 1'b1;
      if (mode_q == MODE_AVG || mode_q == MODE_LOSSY) arm_q <= arm_eff;
    end
  end

  p_left_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != MODE_IDLE |=> mode_q != MODE_IDLE);
  p_acq_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_i |=> mode_q == MODE_AVG);
  p_avg_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_AVG && !acq_i && seed_vld_o) |=> mode_q == MODE_LOSSY);
  p_wait_found_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LOSSY && !acq_i && arm_q && !sfs_found_i) |=> mode_q == MODE_LOSSY);
  p_no_early_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LOSSY && !acq_i && !sfs_found_i && bcnt_q < RES_LIM) |=> mode_q == MODE_LOSSY);
  p_resid_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RESID && !acq_i) |=> mode_q == MODE_RESID);
endmodule

// File: rtl/lvl_peak.sv
`timescale 1ns/1ps
module lvl_peak
  import lvl_acq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter bit IS_POS   = 1'b1,
  parameter int ATK_SH   = 2,
  parameter int DEC_SH   = 6,
  parameter int AVG_SH   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  lvl_mode_e                  mode_i,
  input  res_mode_e                  res_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [SAMPLE_W-1:0] dc_i,
  input  logic                       seed_vld_i,
  input  logic signed [SAMPLE_W-1:0] seed_i,
  output logic signed [SAMPLE_W-1:0] est_o
);
  localparam int DW = SAMPLE_W + 1;

  logic signed [SAMPLE_W-1:0] est_q, est_d;
  logic signed [DW-1:0] s_x, e_x, diff, step_l, sum_l, sum_a;
  logic toward, own_side;

  assign s_x    = {sample_i[SAMPLE_W-1], sample_i};
  assign e_x    = {est_q[SAMPLE_W-1], est_q};
  assign diff   = s_x - e_x;

  generate
    if (IS_POS) begin : g_up
      assign toward   = diff > 0;
      assign own_side = sample_i > dc_i;
    end else begin : g_dn
      assign toward   = diff < 0;
      assign own_side = sample_i < dc_i;
    end
  endgenerate

  assign step_l = toward ? (diff >>> ATK_SH) : (diff >>> DEC_SH);
  assign sum_l  = e_x + step_l;
  assign sum_a  = e_x + (diff >>> AVG_SH);

  always_comb begin
    est_d = est_q;
    if (seed_vld_i) est_d = seed_i;
    else if (mode_i == MODE_LOSSY) est_d = sum_l[SAMPLE_W-1:0];
    else if (mode_i == MODE_RESID) begin
      unique case (res_i)
        RES_LOSSY: est_d = sum_l[SAMPLE_W-1:0];
        RES_PEAK:  if (toward) est_d = sample_i;
        RES_AVG:   if (own_side) est_d = sum_a[SAMPLE_W-1:0];
        default:   est_d = est_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) est_q <= '0;
    else         est_q <= est_d;
  end

  assign est_o = est_q;

  p_lossy_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOSSY && !seed_vld_i && sample_i >= est_q)
    |=> (est_q >= $past(est_q) && est_q <= $past(sample_i)));
  p_lossy_dn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOSSY && !seed_vld_i && sample_i <= est_q)
    |=> (est_q <= $past(est_q) && est_q >= $past(sample_i)));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RESID && res_i == RES_HOLD) |=> $stable(est_q));

  generate
    if (IS_POS) begin : g_chk_up
      p_peak_jump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_RESID && res_i == RES_PEAK && sample_i > est_q) |=> est_q == $past(sample_i));
    end else begin : g_chk_dn
      p_peak_jump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_RESID && res_i == RES_PEAK && sample_i < est_q) |=> est_q == $past(sample_i));
    end
  endgenerate
endmodule

// File: rtl/lvl_acq_ctrl.sv
`timescale 1ns/1ps
module lvl_acq_ctrl
  import lvl_acq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int SPB_LOG2 = 3,
  parameter int BCNT_W   = 6,
  parameter int ARM_WIN  = 28,
  parameter int RES_BITS = 30,
  parameter int ATK_SH   = 2,
  parameter int DEC_SH   = 6,
  parameter int AVG_SH   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       bit_stb_i,
  input  logic                       acq_i,
  input  logic                       sfs_armed_i,
  input  logic                       sfs_found_i,
  input  logic [1:0]                 res_mode_i,
  output logic signed [SAMPLE_W-1:0] pos_pk_o,
  output logic signed [SAMPLE_W-1:0] neg_pk_o,
  output logic signed [SAMPLE_W-1:0] dc_o,
  output logic signed [SAMPLE_W-1:0] amp_o,
  output logic [1:0]                 mode_o
);
  localparam int DW = SAMPLE_W + 1;

  lvl_mode_e                  mode;
  logic                       seed_vld;
  logic signed [SAMPLE_W-1:0] seed;
  logic signed [SAMPLE_W-1:0] est [2];
  logic signed [DW-1:0]       mid_sum, span, mid_sh, span_sh;

  lvl_seq #(
    .SAMPLE_W(SAMPLE_W), .SPB_LOG2(SPB_LOG2), .BCNT_W(BCNT_W),
    .ARM_WIN(ARM_WIN), .RES_BITS(RES_BITS)
  ) u_seq (
    .clk_i, .rst_ni, .sample_i, .acq_i, .bit_stb_i, .sfs_armed_i, .sfs_found_i,
    .mode_o(mode), .seed_vld_o(seed_vld), .seed_o(seed)
  );

  // est[0] upper peak, est[1] lower peak
  for (genvar g = 0; g < 2; g++) begin : g_pk
    lvl_peak #(
      .SAMPLE_W(SAMPLE_W), .IS_POS(g == 0), .ATK_SH(ATK_SH),
      .DEC_SH(DEC_SH), .AVG_SH(AVG_SH)
    ) u_pk (
      .clk_i, .rst_ni, .mode_i(mode), .res_i(res_mode_e'(res_mode_i)),
      .sample_i, .dc_i(dc_o), .seed_vld_i(seed_vld), .seed_i(seed), .est_o(est[g])
    );
  end

  assign mid_sum = {est[0][SAMPLE_W-1], est[0]} + {est[1][SAMPLE_W-1], est[1]};
  assign span    = {est[0][SAMPLE_W-1], est[0]} - {est[1][SAMPLE_W-1], est[1]};
  assign mid_sh  = mid_sum >>> 1;
  assign span_sh = span >>> 1;

  assign pos_pk_o = est[0];
  assign neg_pk_o = est[1];
  assign dc_o     = mid_sh[SAMPLE_W-1:0];
  assign amp_o    = span_sh[SAMPLE_W-1:0];
  assign mode_o   = mode;
endmodule

// File: tb/lvl_acq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_acq_ctrl_tb_top;
  localparam int W = 12;
  localparam int SPB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [W-1:0] sample_i = '0;
  logic bit_stb_i = 0, acq_i = 0, sfs_armed_i = 0, sfs_found_i = 0;
  logic [1:0] res_mode_i = 2'b00;
  logic signed [W-1:0] pos_pk_o, neg_pk_o, dc_o, amp_o;
  logic [1:0] mode_o;

  int n_tests = 0, n_fail = 0;
  int bitno = 0;
  int lcg = 12345;
  bit done = 0;

  always #10 clk = ~clk;

  lvl_acq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_i, .bit_stb_i, .acq_i, .sfs_armed_i,
    .sfs_found_i, .res_mode_i, .pos_pk_o, .neg_pk_o, .dc_o, .amp_o, .mode_o
  );

  // behavioural reference
  int m_mode, m_pos, m_neg, m_acc, m_scnt, m_bcnt;
  bit m_arm;

  function automatic int step(int e, int s, bit up, int mode, int res, int dc);
    int d;
    bit tw;
    d  = s - e;
    tw = up ? (d > 0) : (d < 0);
    if (mode == 2 || (mode == 3 && res == 0)) return tw ? e + (d >>> 2) : e + (d >>> 6);
    if (mode == 3 && res == 1) return tw ? s : e;
    if (mode == 3 && res == 2) return (up ? (s > dc) : (s < dc)) ? e + (d >>> 4) : e;
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pos = 0; m_neg = 0; m_acc = 0; m_scnt = 0; m_bcnt = 0; m_arm = 0;
    end else begin
      int s, dc, np, nn, nm;
      bit ae;
      s  = int'(sample_i);
      dc = (m_pos + m_neg) >>> 1;
      np = m_pos; nn = m_neg;
      if (m_mode == 1 && m_scnt == SPB - 1) begin
        np = (m_acc + s) >>> 3; nn = np;
      end else if (m_mode >= 2) begin
        np = step(m_pos, s, 1, m_mode, int'(res_mode_i), dc);
        nn = step(m_neg, s, 0, m_mode, int'(res_mode_i), dc);
      end
      ae = m_arm || (sfs_armed_i && m_bcnt < 28);
      if (acq_i) begin
        m_mode = 1; m_acc = 0; m_scnt = 0; m_bcnt = 0; m_arm = 0;
      end else begin
        nm = m_mode;
        if (m_mode == 1 && m_scnt == SPB - 1) nm = 2;
        if (m_mode == 2 && ((ae && sfs_found_i) || (!ae && m_bcnt >= 30))) nm = 3;
        if (m_mode == 1) begin m_acc += s; m_scnt = (m_scnt + 1) % SPB; end
        if (bit_stb_i && m_mode != 0 && m_bcnt < 63) m_bcnt++;
        if (m_mode == 1 || m_mode == 2) m_arm = ae;
        m_mode = nm;
      end
      m_pos = np; m_neg = nn;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(int'(mode_o) == m_mode, "R2 mode", int'(mode_o), m_mode);
    check(int'(pos_pk_o) == m_pos, "R4 pos", int'(pos_pk_o), m_pos);
    check(int'(neg_pk_o) == m_neg, "R4 neg", int'(neg_pk_o), m_neg);
    check(int'(dc_o) == ((m_pos + m_neg) >>> 1), "R8 dc", int'(dc_o), (m_pos + m_neg) >>> 1);
    check(int'(amp_o) == ((m_pos - m_neg) >>> 1), "R8 amp", int'(amp_o), (m_pos - m_neg) >>> 1);
  end

  task automatic cyc(int s, bit stb, bit acq = 0, bit found = 0);
    sample_i = W'(s); bit_stb_i = stb; acq_i = acq; sfs_found_i = found;
    @(negedge clk);
  endtask

  task automatic acquire();
    cyc(0, 0, 1);
    bitno = 0;
  endtask

  task automatic bits(int n, int amp, int off);
    for (int b = 0; b < n; b++) begin
      bit hi = (bitno % 4) < 2;
      for (int k = 0; k < SPB; k++) begin
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        cyc(off + (hi ? amp : -amp) + (lcg % 15) - 7, k == SPB - 1);
      end
      bitno++;
    end
  endtask

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int p, n, e;
    repeat (3) @(negedge clk);
    check(mode_o == 2'd0 && pos_pk_o == 0 && neg_pk_o == 0, "R1 reset", int'(mode_o), 0);
    rst_n = 1;
    @(negedge clk);

    // lossy acquisition on 1100, no frame-sync search
    acquire();
    check(mode_o == 2'd1, "R2 acq", int'(mode_o), 1);
    bits(1, 1000, 200);
    check(mode_o == 2'd2 && pos_pk_o == neg_pk_o && iabs(int'(pos_pk_o) - 1200) <= 8,
          "R3 seed", int'(pos_pk_o), 1200);
    bits(13, 1000, 200);
    check(iabs(int'(pos_pk_o) - 1200) <= 125, "R9 pos settle", int'(pos_pk_o), 1200);
    bits(2, 1000, 200);
    check(iabs(int'(neg_pk_o) + 800) <= 125, "R9 neg settle", int'(neg_pk_o), -800);
    bits(14, 1000, 200);
    check(mode_o == 2'd2, "R6 before timeout", int'(mode_o), 2);
    bits(1, 1000, 200);
    check(mode_o == 2'd3, "R6 timeout", int'(mode_o), 3);
    check(int'(amp_o) == ((int'(pos_pk_o) - int'(neg_pk_o)) >>> 1), "R8 amp", int'(amp_o),
          (int'(pos_pk_o) - int'(neg_pk_o)) >>> 1);

    // armed search, restart from residual, peak detect
    res_mode_i = 2'b01;
    acquire();
    check(mode_o == 2'd1, "R2 restart", int'(mode_o), 1);
    bits(4, 900, 100);
    sfs_armed_i = 1;
    bits(36, 900, 100);
    check(mode_o == 2'd2, "R5 wait found", int'(mode_o), 2);
    cyc(100, 0, 0, 1);
    check(mode_o == 2'd3, "R5 found", int'(mode_o), 3);
    p = int'(pos_pk_o); n = int'(neg_pk_o);
    cyc(p + 100, 0);
    check(int'(pos_pk_o) == p + 100, "R7 peak jump", int'(pos_pk_o), p + 100);
    check(int'(neg_pk_o) == n, "R7 peak hold neg", int'(neg_pk_o), n);

    // peak averaging
    res_mode_i = 2'b10;
    p = int'(pos_pk_o);
    cyc(p - 64, 0);
    check(int'(pos_pk_o) == p + ((-64) >>> 4), "R7 averaging", int'(pos_pk_o), p - 4);
    bits(8, 900, 100);

    // hold
    res_mode_i = 2'b11;
    p = int'(pos_pk_o); n = int'(neg_pk_o);
    for (int k = 0; k < 10; k++) cyc((k % 2) ? 2000 : -2000, k == 7);
    check(int'(pos_pk_o) == p && int'(neg_pk_o) == n, "R7 hold", int'(pos_pk_o), p);

    // acquire during averaging, late arming
    sfs_armed_i = 0;
    res_mode_i = 2'b00;
    acquire();
    cyc(-1500, 0); cyc(-1500, 0); cyc(-1500, 0);
    acquire();
    check(mode_o == 2'd1, "R2 acq in avg", int'(mode_o), 1);
    for (int k = 0; k < SPB; k++) cyc(500, k == SPB - 1);
    bitno = 1;
    check(pos_pk_o == 500 && neg_pk_o == 500, "R2 fresh mean", int'(pos_pk_o), 500);
    bits(27, 700, -50);
    sfs_armed_i = 1;
    bits(2, 700, -50);
    check(mode_o == 2'd2, "R6 late arm", int'(mode_o), 2);
    bits(1, 700, -50);
    check(mode_o == 2'd3, "R6 late arm ignored", int'(mode_o), 3);
    e = (int'(pos_pk_o) + int'(neg_pk_o)) >>> 1;
    check(int'(dc_o) == e, "R8 dc", int'(dc_o), e);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule